// File: doc/BRIEF.md
# Floating-Point Status Word Updater

This block keeps the 32-bit status word of a floating-point unit and refreshes it each time the unit finishes an operation. With each completion the block receives the class of the operation, the raw result as an IEEE double, the quotient sign and magnitude from a modulo or remainder step, and the exception flags that the operation raised. A small combinational front end sorts the result into sign, zero, infinity and not-a-number indicators. The condition-code, quotient and exception bytes each follow their own rule about which operation classes may change them.

The quotient byte is special in that it is sticky. It changes only when a modulo or remainder operation completes, and later operations leave it alone until software overwrites the word. A software write port loads the whole word, and that port wins over any hardware update in the same cycle.

Top module: `fpsr_updater`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, stat_o reads 0x00000000.
- R2: The result classification writes {N,Z,I,NAN} to bits 27..24. NAN is set when the exponent is all ones and the fraction is nonzero. I is set when the exponent is all ones and the fraction is zero. Z is set when the exponent and the fraction are both zero. N copies the sign bit for every result, including zero and NaN. A denormal sets none of Z, I and NAN.
- R3: A completion with opc_i = 0 (arithmetic) or opc_i = 1 (modulo/remainder) writes bits 27..24 on the next clock edge.
- R4: A completion with opc_i = 2 (store to memory), 3 (multiple-register move) or 4 (control-register move) leaves bits 27..24 unchanged.
- R5: Only a completion with opc_i = 1 writes the quotient byte. Bit 23 takes quo_sign_i and bits 22..16 take the seven low bits of quo_mag_i.
- R6: Every other completion class, and every idle cycle, leaves bits 23..16 unchanged.
- R7: A completion with opc_i = 0, 1 or 2 replaces bits 15..8 with exc_i. From bit 15 down to bit 8 the flags are BSUN, SNAN, OPERR, OVFL, UNFL, DZ, INEXACT2 and INEXACT1, so flags from earlier operations are dropped.
- R8: A completion with opc_i = 3 or 4 leaves bits 15..8 unchanged.
- R9: The word does not change when done_i is low, or when opc_i is 5, 6 or 7 (reserved).
- R10: Only a software write changes bits 31..28 and bits 7..0.
- R11: When sw_we_i is high, stat_o equals sw_data_i after the next clock edge, even if a hardware completion occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears the word |
| done_i | input | 1 | Operation-completed strobe |
| opc_i | input | 3 | Operation class of the completing operation |
| res_i | input | EXP_W+FRAC_W+1 | Raw result value to be classified |
| quo_sign_i | input | 1 | Sign of the whole quotient |
| quo_mag_i | input | QMAG_W | Unsigned quotient magnitude |
| exc_i | input | 8 | Exception flags raised by the operation |
| sw_we_i | input | 1 | Software write enable |
| sw_data_i | input | 32 | Software write data |
| stat_o | output | 32 | Current status word |

## Verification
The assertions assume that opc_i and the data inputs are held steady across each clock edge, and that sw_data_i may carry any pattern. They also assume that reserved class codes, or any class code presented while done_i is low, must have no effect. The stimulus changes every input only on the falling edge. It draws class codes from the full 3-bit range, including the reserved values and idle cycles, and mixes in occasional software writes, some of which coincide with a completion. Results are drawn from the zero, infinity, NaN, normal and denormal regions with either sign, so that all four classification bits are exercised.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   // status word layout
   localparam int STAT_W   = 32;
   localparam int CC_LSB   = 24;
   localparam int CC_W     = 4;
   localparam int QUO_LSB  = 16;
   localparam int QUO_W    = 7;
   localparam int EXC_LSB  = 8;
   localparam int EXC_W    = 8;

   // operation class codes
   localparam logic [2:0] OPC_ARITH = 3'd0;
   localparam logic [2:0] OPC_REMQ  = 3'd1;
   localparam logic [2:0] OPC_STORE = 3'd2;
   localparam logic [2:0] OPC_MULTI = 3'd3;
   localparam logic [2:0] OPC_CTRL  = 3'd4;

   typedef struct packed {
      logic cc_we;
      logic quo_we;
      logic exc_we;
   } upd_t;
endpackage

// File: rtl/fp_classify.sv
module fp_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] val_i,
   output logic [3:0]            cls_o   // {neg, zero, inf, nan}
);
   localparam int FP_W = EXP_W + FRAC_W + 1;

   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic exp_ones, exp_zero, frac_zero;

   assign expo      = val_i[FRAC_W +: EXP_W];
   assign frac      = val_i[FRAC_W-1:0];
   assign exp_ones  = &expo;
   assign exp_zero  = ~|expo;
   assign frac_zero = ~|frac;

   assign cls_o = {val_i[FP_W-1],
                   exp_zero & frac_zero,
                   exp_ones & frac_zero,
                   exp_ones & ~frac_zero};
endmodule

// File: rtl/fpsr_policy.sv
module fpsr_policy
   import fpsr_pkg::*;
(
   input  logic       done_i,
   input  logic [2:0] opc_i,
   output upd_t       upd_o
);
   always_comb begin
      upd_o = '0;
      if (done_i) begin
         case (opc_i)
            OPC_ARITH: begin
               upd_o.cc_we  = 1'b1;
               upd_o.exc_we = 1'b1;
            end
            OPC_REMQ: begin
               upd_o.cc_we  = 1'b1;
               upd_o.quo_we = 1'b1;
               upd_o.exc_we = 1'b1;
            end
            OPC_STORE: upd_o.exc_we = 1'b1;
            default:   upd_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/fpsr_word.sv
module fpsr_word
   import fpsr_pkg::*;
#(
   parameter int QMAG_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  upd_t              upd_i,
   input  logic [CC_W-1:0]   cls_i,
   input  logic              quo_sign_i,
   input  logic [QMAG_W-1:0] quo_mag_i,
   input  logic [EXC_W-1:0]  exc_i,
   input  logic              sw_we_i,
   input  logic [STAT_W-1:0] sw_data_i,
   output logic [STAT_W-1:0] word_o
);
   logic [QUO_W-1:0]  quo_low;
   logic [STAT_W-1:0] word_q, word_d;

   generate
      if (QMAG_W > QUO_W) begin : g_quo_trunc
         logic unused_quo_hi;
         assign quo_low       = quo_mag_i[QUO_W-1:0];
         assign unused_quo_hi = ^quo_mag_i[QMAG_W-1:QUO_W];
      end else if (QMAG_W == QUO_W) begin : g_quo_exact
         assign quo_low = quo_mag_i;
      end else begin : g_quo_pad
         assign quo_low = {{(QUO_W-QMAG_W){1'b0}}, quo_mag_i};
      end
   endgenerate

   always_comb begin
      word_d = word_q;
      if (upd_i.cc_we)  word_d[CC_LSB +: CC_W]       = cls_i;
      if (upd_i.quo_we) word_d[QUO_LSB +: QUO_W+1]   = {quo_sign_i, quo_low};
      if (upd_i.exc_we) word_d[EXC_LSB +: EXC_W]     = exc_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (sw_we_i) word_q <= sw_data_i;
      else              word_q <= word_d;
   end

   assign word_o = word_q;
endmodule

// File: rtl/fpsr_updater.sv
module fpsr_updater
   import fpsr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int QMAG_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  done_i,
   input  logic [2:0]            opc_i,
   input  logic [EXP_W+FRAC_W:0] res_i,
   input  logic                  quo_sign_i,
   input  logic [QMAG_W-1:0]     quo_mag_i,
   input  logic [7:0]            exc_i,
   input  logic                  sw_we_i,
   input  logic [31:0]           sw_data_i,
   output logic [31:0]           stat_o
);
   generate
      if (EXP_W < 2)   begin : g_bad_exp  $error("EXP_W must be at least 2");  end
      if (FRAC_W < 1)  begin : g_bad_frac $error("FRAC_W must be at least 1"); end
      if (QMAG_W < 1)  begin : g_bad_qmag $error("QMAG_W must be at least 1"); end
   endgenerate

   upd_t            upd;
   logic [CC_W-1:0] cls;

   fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i (res_i),
      .cls_o (cls)
   );

   fpsr_policy u_pol (
      .done_i (done_i),
      .opc_i  (opc_i),
      .upd_o  (upd)
   );

   fpsr_word #(.QMAG_W(QMAG_W)) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_i      (upd),
      .cls_i      (cls),
      .quo_sign_i (quo_sign_i),
      .quo_mag_i  (quo_mag_i),
      .exc_i      (exc_i),
      .sw_we_i    (sw_we_i),
      .sw_data_i  (sw_data_i),
      .word_o     (stat_o)
   );
endmodule

// File: rtl/fpsr_updater_chk.sv
module fpsr_updater_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        done_i,
   input logic [2:0]  opc_i,
   input logic        sw_we_i,
   input logic [31:0] sw_data_i,
   input logic [31:0] stat_o
);
   logic cc_hold, quo_hold, exc_hold, arith_upd;
   assign cc_hold   = !sw_we_i && (!done_i || opc_i > 3'd1);
   assign quo_hold  = !sw_we_i && !(done_i && opc_i == 3'd1);
   assign exc_hold  = !sw_we_i && (!done_i || opc_i > 3'd2);
   assign arith_upd = !sw_we_i && done_i && opc_i <= 3'd1;

   assert_cc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cc_hold |=> $stable(stat_o[27:24]));
   assert_quo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      quo_hold |=> $stable(stat_o[23:16]));
   assert_exc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_hold |=> $stable(stat_o[15:8]));
   assert_class_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arith_upd |=> $onehot0(stat_o[26:24]));
   assert_outer_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we_i |=> ($stable(stat_o[31:28]) && $stable(stat_o[7:0])));
   assert_sw_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we_i |=> (stat_o == $past(sw_data_i)));
   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we_i && (!done_i || opc_i > 3'd4)) |=> $stable(stat_o));
endmodule

bind fpsr_updater fpsr_updater_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done_i    (done_i),
   .opc_i     (opc_i),
   .sw_we_i   (sw_we_i),
   .sw_data_i (sw_data_i),
   .stat_o    (stat_o)
);

// File: tb/test_fpsr_updater.sv
`timescale 1ns/1ps
module test_fpsr_updater;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done_i = 1'b0;
   logic [2:0]  opc_i = '0;
   logic [63:0] res_i = '0;
   logic        quo_sign_i = 1'b0;
   logic [15:0] quo_mag_i = '0;
   logic [7:0]  exc_i = '0;
   logic        sw_we_i = 1'b0;
   logic [31:0] sw_data_i = '0;
   logic [31:0] stat_o;

   int total = 0;
   int bad = 0;
   logic [31:0] model = '0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   fpsr_updater i_fpsr_updater (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .opc_i(opc_i), .res_i(res_i),
      .quo_sign_i(quo_sign_i), .quo_mag_i(quo_mag_i), .exc_i(exc_i),
      .sw_we_i(sw_we_i), .sw_data_i(sw_data_i), .stat_o(stat_o));

   function automatic logic [3:0] classify(input logic [63:0] v);
      logic [10:0] e;
      logic [51:0] f;
      e = v[62:52];
      f = v[51:0];
      return {v[63], (e == 11'd0 && f == 52'd0), (e == 11'h7FF && f == 52'd0),
              (e == 11'h7FF && f != 52'd0)};
   endfunction

   function automatic logic [31:0] predict(input logic [31:0] old, input logic dn,
         input logic [2:0] oc, input logic [63:0] r, input logic qs,
         input logic [15:0] qm, input logic [7:0] ex, input logic we,
         input logic [31:0] wd);
      logic [31:0] n;
      n = old;
      if (we) return wd;
      if (dn && (oc == 3'd0 || oc == 3'd1)) n[27:24] = classify(r);
      if (dn && oc == 3'd1) n[23:16] = {qs, qm[6:0]};
      if (dn && oc <= 3'd2) n[15:8] = ex;
      return n;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input logic dn, input logic [2:0] oc, input logic [63:0] r,
         input logic qs, input logic [15:0] qm, input logic [7:0] ex,
         input logic we, input logic [31:0] wd);
      string tcc, tq, tex;
      @(negedge clk);
      done_i = dn; opc_i = oc; res_i = r; quo_sign_i = qs; quo_mag_i = qm;
      exc_i = ex; sw_we_i = we; sw_data_i = wd;
      model = predict(model, dn, oc, r, qs, qm, ex, we, wd);
      @(posedge clk);
      #1;
      if (we) begin
         check("R11", stat_o, model);
      end else begin
         if (!dn || oc > 3'd4) begin tcc = "R9"; tq = "R9"; tex = "R9"; end
         else begin
            tcc = (oc <= 3'd1) ? "R3" : "R4";
            tq  = (oc == 3'd1) ? "R5" : "R6";
            tex = (oc <= 3'd2) ? "R7" : "R8";
         end
         check(tcc, {28'd0, stat_o[27:24]}, {28'd0, model[27:24]});
         check(tq,  {24'd0, stat_o[23:16]}, {24'd0, model[23:16]});
         check(tex, {24'd0, stat_o[15:8]},  {24'd0, model[15:8]});
         check("R10", {20'd0, stat_o[31:28], stat_o[7:0]},
               {20'd0, model[31:28], model[7:0]});
      end
   endtask

   function automatic logic [63:0] pick_res(input int kind, input logic s);
      logic [51:0] f;
      logic [10:0] e;
      f = {$urandom, $urandom} | 52'd1;
      e = 11'($urandom_range(1, 2046));
      case (kind)
         0: return {s, 63'd0};
         1: return {s, 11'h7FF, 52'd0};
         2: return {s, 11'h7FF, f};
         3: return {s, e, f};
         4: return {s, 11'd0, f};
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      repeat (3) @(posedge clk);
      #1;
      check("R1 in reset", stat_o, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 after release", stat_o, 32'h0);

      // R2 classification corner cases
      step(1, 3'd0, {1'b1, 63'd0}, 0, 0, 8'h01, 0, 0);
      check("R2 neg zero", {28'd0, stat_o[27:24]}, 32'hC);
      step(1, 3'd0, {1'b0, 11'h7FF, 52'd0}, 0, 0, 8'h10, 0, 0);
      check("R2 pos inf", {28'd0, stat_o[27:24]}, 32'h2);
      step(1, 3'd0, {1'b1, 11'h7FF, 52'd5}, 0, 0, 8'h40, 0, 0);
      check("R2 neg nan", {28'd0, stat_o[27:24]}, 32'h9);
      step(1, 3'd0, {1'b1, 11'd0, 52'd3}, 0, 0, 8'h00, 0, 0);
      check("R2 neg denormal", {28'd0, stat_o[27:24]}, 32'h8);

      // R5/R6 quotient sticky
      step(1, 3'd1, {1'b0, 11'd1023, 52'd0}, 1, 16'hFF85, 8'h00, 0, 0);
      check("R5 quotient", {24'd0, stat_o[23:16]}, 32'h85);
      step(1, 3'd0, 64'd0, 0, 16'h0000, 8'h00, 0, 0);
      step(1, 3'd2, 64'd0, 0, 16'h0011, 8'h02, 0, 0);
      check("R6 sticky", {24'd0, stat_o[23:16]}, 32'h85);

      // R11 software write beats a completion
      step(1, 3'd1, {1'b1, 63'd0}, 0, 16'h7, 8'hFF, 1, 32'hA5A5_0F0F);
      check("R11 priority", stat_o, 32'hA5A5_0F0F);
      step(0, 3'd0, 64'd0, 0, 0, 0, 1, 32'h0);
      check("R11 clear", stat_o, 32'h0);

      for (int i = 0; i < 600; i++) begin
         logic dn, we;
         logic [2:0] oc;
         dn = ($urandom_range(0, 9) != 0);
         oc = 3'($urandom_range(0, 7));
         we = ($urandom_range(0, 11) == 0);
         step(dn, oc, pick_res($urandom_range(0, 5), 1'($urandom)), 1'($urandom),
              16'($urandom), 8'($urandom), we, $urandom);
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule